// File: doc/BRIEF.md
# Reference Pulse Oscillator Calibrator

This block trims a free-running on-chip oscillator against a time reference supplied by the host. A calibration command arms the block. The host then holds chip select low for a known interval: eight periods of the target frequency. The block counts that interval in ticks of the untrimmed oscillator, where one target period is nominally 16 ticks, so a perfect oscillator measures 128 ticks. It then derives a trim code that stretches or shrinks the oscillator period toward the target.

The oscillator is modelled as a period of `(128 + trim) / 128` untrimmed periods. The ideal trim is therefore the measured count minus 128.

- The oscillator tolerance before trimming is +70 % to −35 %. The count range that is accepted covers all of it.
- A maximum-frequency option adds a fixed bias toward lower frequency. With it, the residual ±10 % error never takes the clock above the target.
- A slow option is latched at arm and drives the oscillator's divide-by-1.5 select. The reference pulse is then 12 µs, which is again eight slowed target periods, so the nominal count does not change.

While a calibration is running, chip select is a timing reference and not a frame. The block therefore holds the chip-select copy that it passes to the serial interface high. A pulse length the trim cannot correct, or a pulse that does not end in time, raises a fault bit and leaves the previous trim in place.

Top module: `refpulse_trim_cal`

## Requirements
- R1: After reset `trim_code` = 0, `cal_busy` = 0, `cal_fault` = 0 and `osc_slow` = 0.
- R2: A `cal_arm` pulse while idle sets `cal_busy` at the next clock edge. That edge also latches `sel_slow` into `osc_slow` and `sel_max` internally. A `cal_arm` pulse while busy has no effect on the measurement.
- R3: The measured count M is the number of rising clock edges at which `cs_sync_n` is sampled low, starting at the first low sample after arm. The measurement ends at the first edge that samples `cs_sync_n` high. At that edge `cal_busy` clears and the outputs are updated.
- R4: In centred mode (`sel_max` = 0) the new trim is M − 128, in 8-bit two's complement (for example, M = 100 gives 0xE4).
- R5: In maximum mode (`sel_max` = 1) the new trim is M − 128 + 13.
- R6: In slow mode a pulse of exactly 128 counts yields trim 0, `cal_fault` = 0 and `osc_slow` = 1.
- R7: If M < 64, `cal_fault` is set and `trim_code` keeps its previous value.
- R8: If the computed trim exceeds +127, `cal_fault` is set and `trim_code` keeps its previous value. M = 255 in centred mode is still accepted and gives trim 127.
- R9: If `cs_sync_n` is sampled low on 256 edges in a row, the block times out. It sets `cal_fault`, clears `cal_busy` and keeps `trim_code`.
- R10: `frame_cs_n` is held at 1 while `cal_busy` is high and follows `cs_sync_n` while idle.
- R11: Accepting a new arm clears `cal_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled oscillator tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_sync_n | input | 1 | Synchronized chip-select level, low during the reference pulse |
| cal_arm | input | 1 | One-cycle strobe: calibration command accepted |
| sel_max | input | 1 | 1 = keep the clock below the target, 0 = centre it on the target |
| sel_slow | input | 1 | 1 = slowed oscillator with a 12 µs reference |
| trim_code | output | 8 | Signed oscillator period trim |
| cal_busy | output | 1 | Calibration in progress |
| cal_fault | output | 1 | Last calibration failed |
| osc_slow | output | 1 | Latched slow select for the oscillator |
| frame_cs_n | output | 1 | Chip select forwarded to the serial interface |

## Verification
The trim arithmetic is tried with pulse lengths on both sides of the nominal 128. The lengths include the exact limits of the accepted range (64 and 255) and lengths just outside it, in both bias modes and with the slow select. This separates an off-by-one in the count, a missing or wrong-signed bias, and a range check on the wrong side. Directed runs add an arm issued while busy, an over-long pulse that must time out, and the masking of chip select. Each fault case also checks that the earlier trim survives.

// File: rtl/refpulse_trim_cal.sv
module refpulse_trim_cal #(
  parameter int TW      = 8,
  parameter int NOM     = 128,
  parameter int CNT_MIN = 64,
  parameter int BIAS    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_sync_n,
  input  logic          cal_arm,
  input  logic          sel_max,
  input  logic          sel_slow,
  output logic [TW-1:0] trim_code,
  output logic          cal_busy,
  output logic          cal_fault,
  output logic          osc_slow,
  output logic          frame_cs_n
);
  localparam int CW = TW + 1;
  localparam logic [CW-1:0] LIM   = CW'((1 << TW) - 1);
  localparam logic [CW-1:0] MIN_C = CW'(CNT_MIN);
  localparam logic [CW:0]   NOM_W = (CW+1)'(NOM);
  localparam logic [CW:0]   HI_W  = (CW+1)'(NOM + (1 << (TW-1)) - 1);
  localparam logic [CW:0]   BIAS_W = (CW+1)'(BIAS);

  typedef enum logic [1:0] {IDLE, WAITL, MEAS} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic          max_q;
  logic [CW:0]   biased;
  logic          bad;

  assign biased     = {1'b0, cnt} + (max_q ? BIAS_W : '0);
  assign bad        = (cnt < MIN_C) || (biased > HI_W);
  assign cal_busy   = (st != IDLE);
  assign frame_cs_n = cs_sync_n | cal_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      max_q     <= 1'b0;
      osc_slow  <= 1'b0;
      cal_fault <= 1'b0;
      trim_code <= '0;
    end else begin
      case (st)
        IDLE: if (cal_arm) begin
          st        <= WAITL;
          osc_slow  <= sel_slow;
          max_q     <= sel_max;
          cal_fault <= 1'b0;
        end
        WAITL: if (!cs_sync_n) begin
          st  <= MEAS;
          cnt <= CW'(1);
        end
        MEAS: if (cs_sync_n) begin
          st <= IDLE;
          if (bad) cal_fault <= 1'b1;
          else     trim_code <= TW'(biased - NOM_W);
        end else if (cnt == LIM) begin
          st        <= IDLE;
          cal_fault <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  arm_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && cal_arm) |=> cal_busy);

  // R2
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy)) |-> $stable(osc_slow));

  // R3
  trim_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim_code) |-> $fell(cal_busy));

  // R7
  fault_keeps_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_fault) |-> $stable(trim_code));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  // R11
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && cal_arm) |=> !cal_fault);
endmodule

// File: tb/refpulse_trim_cal_test.sv
module refpulse_trim_cal_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_sync_n = 1'b1, cal_arm = 1'b0, sel_max = 1'b0, sel_slow = 1'b0;
  logic [7:0] trim_code;
  logic cal_busy, cal_fault, osc_slow, frame_cs_n;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_trim = 8'h00;
  logic       exp_fault = 1'b0;

  always #2.5 clk = ~clk;

  refpulse_trim_cal uut (.clk, .rst_n, .cs_sync_n, .cal_arm, .sel_max, .sel_slow,
    .trim_code, .cal_busy, .cal_fault, .osc_slow, .frame_cs_n);

  typedef struct packed { logic [8:0] len; logic mx; logic slw; } vec_t;
  localparam vec_t VECS [10] = '{
    '{9'd128, 1'b0, 1'b0}, '{9'd100, 1'b0, 1'b0}, '{9'd200, 1'b0, 1'b0},
    '{9'd128, 1'b1, 1'b0}, '{9'd83,  1'b1, 1'b0}, '{9'd217, 1'b0, 1'b1},
    '{9'd40,  1'b0, 1'b0}, '{9'd250, 1'b1, 1'b0}, '{9'd255, 1'b0, 1'b0},
    '{9'd64,  1'b0, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 R5 R7 R8 R9: expected outcome from the requirement formulas
  task automatic predict(input int len, input logic mx);
    int code = len - 128 + (mx ? 13 : 0);
    if (len >= 256 || len < 64 || code > 127) exp_fault = 1'b1;
    else begin exp_fault = 1'b0; exp_trim = 8'(code); end
  endtask

  task automatic calibrate(input int len, input logic mx, input logic slw, input string req);
    @(negedge clk); cal_arm = 1'b1; sel_max = mx; sel_slow = slw;
    @(negedge clk); cal_arm = 1'b0;
    chk("R2 busy after arm", 32'(cal_busy), 32'd1);
    chk("R2 slow latched", 32'(osc_slow), 32'(slw));
    @(negedge clk);
    cs_sync_n = 1'b0;
    for (int i = 0; i < len; i++) @(negedge clk);
    cs_sync_n = 1'b1;
    @(negedge clk);
    predict(len, mx);
    chk({req, " busy cleared"}, 32'(cal_busy), 32'd0);
    chk({req, " trim"}, 32'(trim_code), 32'(exp_trim));
    chk({req, " fault"}, 32'(cal_fault), 32'(exp_fault));
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 trim", 32'(trim_code), 32'd0);
    chk("R1 busy", 32'(cal_busy), 32'd0);
    chk("R1 fault", 32'(cal_fault), 32'd0);
    chk("R1 slow", 32'(osc_slow), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R8 table walk
    foreach (VECS[k]) calibrate(int'(VECS[k].len), VECS[k].mx, VECS[k].slw, "R4/R5/R7/R8 vec");

    // R6 slow nominal
    calibrate(128, 1'b0, 1'b1, "R6 slow nominal");
    chk("R6 osc_slow", 32'(osc_slow), 32'd1);

    // R10 idle pass-through
    cs_sync_n = 1'b0; @(negedge clk);
    chk("R10 idle low", 32'(frame_cs_n), 32'd0);
    cs_sync_n = 1'b1; @(negedge clk);
    chk("R10 idle high", 32'(frame_cs_n), 32'd1);

    // R2 R10 arm while busy ignored, cs masked
    cal_arm = 1'b1; sel_max = 1'b0; sel_slow = 1'b0;
    @(negedge clk); cal_arm = 1'b0;
    @(negedge clk);
    cs_sync_n = 1'b0;
    chk("R10 masked while busy", 32'(frame_cs_n), 32'd1);
    for (int i = 0; i < 50; i++) begin
      if (i == 20) begin cal_arm = 1'b1; sel_max = 1'b1; end
      if (i == 21) cal_arm = 1'b0;
      @(negedge clk);
    end
    chk("R10 masked during pulse", 32'(frame_cs_n), 32'd1);
    cs_sync_n = 1'b1; @(negedge clk);
    chk("R2 re-arm ignored busy", 32'(cal_busy), 32'd0);
    chk("R7 short pulse fault", 32'(cal_fault), 32'd1);
    chk("R7 trim kept", 32'(trim_code), 32'd0);

    // R11 fault cleared by arm, then R4 good result
    calibrate(150, 1'b0, 1'b0, "R11 recover");
    chk("R11 fault cleared", 32'(cal_fault), 32'd0);

    // R9 timeout
    @(negedge clk); cal_arm = 1'b1; sel_max = 1'b0;
    @(negedge clk); cal_arm = 1'b0;
    @(negedge clk); cs_sync_n = 1'b0;
    for (int i = 0; i < 255; i++) @(negedge clk);
    chk("R9 still busy at 255", 32'(cal_busy), 32'd1);
    @(negedge clk);
    chk("R9 timeout busy", 32'(cal_busy), 32'd0);
    chk("R9 timeout fault", 32'(cal_fault), 32'd1);
    chk("R9 trim kept", 32'(trim_code), 32'd22);
    repeat (20) @(negedge clk);
    cs_sync_n = 1'b1; @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule